// File: doc/BRIEF.md
# DMA Chunk Address and Count Engine

This block performs one step of a data-phase transfer for a bus-mastering storage controller. A move is loaded as a 24-bit remaining byte count and a low 32-bit data address. The attached device reports how many bytes it currently holds or accepts. When started, the block forms a 64-bit memory address and sizes the burst as the smaller of the remaining count and the device length. It then issues one burst request toward memory and holds it until the memory acknowledges it.

The upper 32 address bits are chosen from three candidate registers according to a mode control byte. After the acknowledge the block advances the address, shrinks the remaining count, shrinks the device length and grows a cumulative byte counter. It then reports with a one-cycle pulse what the sequencer must do next. If the device buffer is drained, the pulse is "write complete" for outbound data and "request more data" for inbound data. Otherwise the pulse is "resume".

Top module: `dma_chunk_engine`

## Requirements
- R1: A synchronous active-high reset clears the remaining count, the current address, the cumulative counter and the device length, and leaves the block idle with no request and no pulse.
- R2: While the stored device length is zero after a start, no memory request is raised. The block waits and proceeds once a nonzero length is loaded through `devLenValid`.
- R3: The burst length `memLen` equals the smaller of the remaining move count and the stored device length.
- R4: Mode byte bits [1:0] enable the 40-bit mode, which is active only when both bits are 1. Bit [2] enables the table-indirect 64-bit mode. When either mode is active, the upper address half is `upperNext`.
- R5: When neither mode is active, the upper half is `upperData` if it is nonzero. Failing that it is `upperBlock` if that is nonzero. Otherwise it is zero. The lower half is always the current address.
- R6: `memRead` is 1 for an outbound (`dirOut`=1) transfer and 0 for an inbound one. The request, its address, its length and its direction stay stable until `memAck` is seen.
- R7: In the cycle the acknowledge is taken, the cumulative counter grows by the burst length, the address advances by it, and the remaining count drops by it.
- R8: If the device length becomes zero with the burst, the block pulses `writeDone` for outbound transfers or `readMore` for inbound ones. Otherwise it pulses `resume`. At most one pulse is active in any cycle.
- R9: A move load is accepted only while idle. Loads of the device length are ignored while a request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadMove | input | 1 | Load remaining count and low address |
| loadCount | input | 24 | Remaining byte count to load |
| loadAddr | input | 32 | Low data address to load |
| upperNext | input | 32 | Upper half from the 64-bit next-address register |
| upperData | input | 32 | Data-move upper selector |
| upperBlock | input | 32 | Static block-move upper selector |
| modeCtl | input | 8 | Mode byte: [1:0] 40-bit enables, [2] table-indirect 64-bit |
| dirOut | input | 1 | 1 = outbound (read host memory) |
| devLenValid | input | 1 | Load device available length |
| devLen | input | 24 | Device available length |
| go | input | 1 | Start one transfer step |
| memReq | output | 1 | Burst request |
| memRead | output | 1 | Burst direction, 1 = read host memory |
| memAddr | output | 64 | Burst address |
| memLen | output | 24 | Burst byte length |
| memAck | input | 1 | Burst acknowledge |
| remCount | output | 24 | Remaining move count |
| curAddr | output | 32 | Current low address |
| cumCount | output | 32 | Cumulative transferred bytes |
| busy | output | 1 | Step in progress |
| writeDone | output | 1 | Pulse: device drained on outbound transfer |
| readMore | output | 1 | Pulse: device drained on inbound transfer |
| resume | output | 1 | Pulse: device not drained, sequencer continues |

## Verification
The assertions check on every cycle that the request, its address and its length are held while the acknowledge is absent. They also check that no request rises over a zero device length, that the burst never exceeds the remaining count, and that the three counters move by exactly the burst length on each acknowledge. They further check that the outcome pulses are mutually exclusive. Only the bench scenarios can show the choice among the three upper-address sources under each mode setting, and the single-bit case of the 40-bit enable. The same holds for the direction-dependent drain pulse and for loads being ignored during a request.

// File: rtl/dma_chunk_pkg.sv
package dma_chunk_pkg;
  localparam int WIDE_EN_LO = 0;
  localparam int WIDE_EN_HI = 1;
  localparam int TABLE_EN   = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2
  } stepState_t;

  typedef struct packed {
    logic capture;
    logic commit;
  } strobe_t;
endpackage

// File: rtl/dma_chunk_path.sv
module dma_chunk_path
  import dma_chunk_pkg::*;
#(
  parameter int CW = 24,
  parameter int AW = 32,
  parameter int UW = 32,
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strobe,
  input  logic          idle,
  input  logic          reqOpen,
  input  logic          loadMove,
  input  logic [CW-1:0] loadCount,
  input  logic [AW-1:0] loadAddr,
  input  logic [UW-1:0] upperNext,
  input  logic [UW-1:0] upperData,
  input  logic [UW-1:0] upperBlock,
  input  logic [7:0]    modeCtl,
  input  logic          devLenValid,
  input  logic [CW-1:0] devLen,
  output logic [UW+AW-1:0] memAddr,
  output logic [CW-1:0] memLen,
  output logic [CW-1:0] remCount,
  output logic [AW-1:0] curAddr,
  output logic [SW-1:0] cumCount,
  output logic [CW-1:0] devLenQ,
  output logic          devZero,
  output logic          drainNow
);
  logic          wideMode;
  logic [UW-1:0] upperSel;
  logic [CW-1:0] sizeNext;

  assign wideMode = (modeCtl[WIDE_EN_LO] & modeCtl[WIDE_EN_HI]) | modeCtl[TABLE_EN];

  always_comb begin
    if (wideMode)               upperSel = upperNext;
    else if (upperData != '0)   upperSel = upperData;
    else if (upperBlock != '0)  upperSel = upperBlock;
    else                        upperSel = '0;
  end

  assign sizeNext = (remCount < devLenQ) ? remCount : devLenQ;
  assign devZero  = (devLenQ == '0);
  assign drainNow = (devLenQ == memLen);

  always_ff @(posedge clk) begin
    if (rst) begin
      remCount <= '0;
      curAddr  <= '0;
      cumCount <= '0;
      devLenQ  <= '0;
      memAddr  <= '0;
      memLen   <= '0;
    end else begin
      if (strobe.capture) begin
        memAddr <= {upperSel, curAddr};
        memLen  <= sizeNext;
      end
      if (strobe.commit) begin
        remCount <= remCount - memLen;
        curAddr  <= curAddr + AW'(memLen);
        cumCount <= cumCount + SW'(memLen);
        devLenQ  <= devLenQ - memLen;
      end else if (devLenValid && !reqOpen) begin
        devLenQ <= devLen;
      end
      if (loadMove && idle) begin
        remCount <= loadCount;
        curAddr  <= loadAddr;
      end
    end
  end
endmodule

// File: rtl/dma_chunk_ctrl.sv
module dma_chunk_ctrl
  import dma_chunk_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    go,
  input  logic    dirOut,
  input  logic    memAck,
  input  logic    devZero,
  input  logic    drainNow,
  output strobe_t strobe,
  output logic    idle,
  output logic    reqOpen,
  output logic    memReq,
  output logic    memRead,
  output logic    busy,
  output logic    writeDone,
  output logic    readMore,
  output logic    resume
);
  stepState_t state, stateNext;

  always_comb begin
    stateNext      = state;
    strobe.capture = 1'b0;
    strobe.commit  = 1'b0;
    unique case (state)
      ST_IDLE: if (go) stateNext = ST_WAIT;
      ST_WAIT: if (!devZero) begin
        stateNext      = ST_REQ;
        strobe.capture = 1'b1;
      end
      ST_REQ: if (memAck) begin
        stateNext     = ST_IDLE;
        strobe.commit = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign idle    = (state == ST_IDLE);
  assign reqOpen = (state == ST_REQ);
  assign memReq  = reqOpen;
  assign busy    = !idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      memRead   <= 1'b0;
      writeDone <= 1'b0;
      readMore  <= 1'b0;
      resume    <= 1'b0;
    end else begin
      state     <= stateNext;
      if (strobe.capture) memRead <= dirOut;
      writeDone <= strobe.commit && drainNow && memRead;
      readMore  <= strobe.commit && drainNow && !memRead;
      resume    <= strobe.commit && !drainNow;
    end
  end
endmodule

// File: rtl/dma_chunk_engine.sv
module dma_chunk_engine
  import dma_chunk_pkg::*;
#(
  parameter int CW = 24,
  parameter int AW = 32,
  parameter int UW = 32,
  parameter int SW = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadMove,
  input  logic [CW-1:0]    loadCount,
  input  logic [AW-1:0]    loadAddr,
  input  logic [UW-1:0]    upperNext,
  input  logic [UW-1:0]    upperData,
  input  logic [UW-1:0]    upperBlock,
  input  logic [7:0]       modeCtl,
  input  logic             dirOut,
  input  logic             devLenValid,
  input  logic [CW-1:0]    devLen,
  input  logic             go,
  output logic             memReq,
  output logic             memRead,
  output logic [UW+AW-1:0] memAddr,
  output logic [CW-1:0]    memLen,
  input  logic             memAck,
  output logic [CW-1:0]    remCount,
  output logic [AW-1:0]    curAddr,
  output logic [SW-1:0]    cumCount,
  output logic             busy,
  output logic             writeDone,
  output logic             readMore,
  output logic             resume
);
  strobe_t       strobe;
  logic          idle, reqOpen, devZero, drainNow;
  logic [CW-1:0] devLenQ;

  dma_chunk_ctrl u_ctrl (
    .clk(clk), .rst(rst), .go(go), .dirOut(dirOut), .memAck(memAck),
    .devZero(devZero), .drainNow(drainNow), .strobe(strobe), .idle(idle),
    .reqOpen(reqOpen), .memReq(memReq), .memRead(memRead), .busy(busy),
    .writeDone(writeDone), .readMore(readMore), .resume(resume)
  );

  dma_chunk_path #(.CW(CW), .AW(AW), .UW(UW), .SW(SW)) u_path (
    .clk(clk), .rst(rst), .strobe(strobe), .idle(idle), .reqOpen(reqOpen),
    .loadMove(loadMove), .loadCount(loadCount), .loadAddr(loadAddr),
    .upperNext(upperNext), .upperData(upperData), .upperBlock(upperBlock),
    .modeCtl(modeCtl), .devLenValid(devLenValid), .devLen(devLen),
    .memAddr(memAddr), .memLen(memLen), .remCount(remCount),
    .curAddr(curAddr), .cumCount(cumCount), .devLenQ(devLenQ),
    .devZero(devZero), .drainNow(drainNow)
  );
endmodule

// File: rtl/dma_chunk_checker.sv
module dma_chunk_checker #(
  parameter int CW = 24,
  parameter int AW = 32,
  parameter int UW = 32,
  parameter int SW = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             memReq,
  input logic             memRead,
  input logic             memAck,
  input logic [UW+AW-1:0] memAddr,
  input logic [CW-1:0]    memLen,
  input logic [CW-1:0]    remCount,
  input logic [AW-1:0]    curAddr,
  input logic [SW-1:0]    cumCount,
  input logic [CW-1:0]    devLenQ,
  input logic             writeDone,
  input logic             readMore,
  input logic             resume
);
  assert_hold_req_R6: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memLen) && $stable(memRead));

  assert_no_req_on_empty_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(memReq) |-> $past(devLenQ) != '0);

  assert_len_bound_R3: assert property (@(posedge clk) disable iff (rst)
    memReq |-> (memLen <= remCount) && (memLen <= devLenQ));

  assert_cum_grow_R7: assert property (@(posedge clk) disable iff (rst)
    memReq && memAck |=> cumCount == $past(cumCount) + SW'($past(memLen)));

  assert_rem_drop_R7: assert property (@(posedge clk) disable iff (rst)
    memReq && memAck |=> remCount == $past(remCount) - $past(memLen));

  assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
    memReq && memAck |=> curAddr == $past(curAddr) + AW'($past(memLen)));

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({writeDone, readMore, resume}));
endmodule

bind dma_chunk_engine dma_chunk_checker #(.CW(CW), .AW(AW), .UW(UW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .memReq(memReq), .memRead(memRead), .memAck(memAck),
  .memAddr(memAddr), .memLen(memLen), .remCount(remCount), .curAddr(curAddr),
  .cumCount(cumCount), .devLenQ(devLenQ), .writeDone(writeDone),
  .readMore(readMore), .resume(resume)
);

// File: tb/tb_dma_chunk_engine.sv
`timescale 1ns/1ps
module tb_dma_chunk_engine;
  logic        clk = 0, rst = 1;
  logic        loadMove = 0, dirOut = 0, devLenValid = 0, go = 0, memAck = 0;
  logic [23:0] loadCount = 0, devLen = 0;
  logic [31:0] loadAddr = 0, upperNext = 0, upperData = 0, upperBlock = 0;
  logic [7:0]  modeCtl = 0;
  logic        memReq, memRead, busy, writeDone, readMore, resume;
  logic [63:0] memAddr;
  logic [23:0] memLen, remCount;
  logic [31:0] curAddr, cumCount;

  int checks = 0, errors = 0;
  longint mRem = 0, mAddr = 0, mCum = 0;

  always #5 clk = ~clk;

  dma_chunk_engine dut (.*);

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model of the counters, compared every clock
  always @(negedge clk) begin
    chk("R7 remCount", remCount, mRem);
    chk("R7 curAddr", curAddr, mAddr);
    chk("R7 cumCount", cumCount, mCum);
    if (rst) begin
      mRem = 0; mAddr = 0; mCum = 0;
    end else if (memReq && memAck) begin
      mRem  = (mRem - memLen) & 24'hFFFFFF;
      mAddr = (mAddr + memLen) & 32'hFFFFFFFF;
      mCum  = (mCum + memLen) & 32'hFFFFFFFF;
    end else if (loadMove && !busy) begin
      mRem = loadCount; mAddr = loadAddr;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic loadM(int cnt, int adr);
    loadCount = cnt; loadAddr = adr; loadMove = 1; tick(); loadMove = 0;
  endtask

  task automatic setDev(int n);
    devLen = n; devLenValid = 1; tick(); devLenValid = 0;
  endtask

  function automatic longint expUpper(logic [7:0] m);
    if ((m[0] && m[1]) || m[2]) return upperNext;
    if (upperData != 0) return upperData;
    if (upperBlock != 0) return upperBlock;
    return 0;
  endfunction

  // run one step: go, wait for request, check it, ack, check outcome pulse
  task automatic step(string tag, longint expLen, int outcome);
    longint eAddr;
    int k = 0;
    eAddr = (expUpper(modeCtl) << 32) | (mAddr & 32'hFFFFFFFF);
    go = 1; tick(); go = 0;
    while (!memReq && k < 20) begin tick(); k++; end
    chk({tag, " R3 memLen"}, memLen, expLen);
    chk({tag, " R4 R5 memAddr"}, memAddr, eAddr);
    chk({tag, " R6 memRead"}, memRead, dirOut);
    memAck = 1; tick(); memAck = 0;
    chk({tag, " R8 pulses"}, {writeDone, readMore, resume}, outcome);
    tick();
    chk({tag, " R8 pulse ends"}, {writeDone, readMore, resume}, 0);
  endtask

  initial begin
    tick(); tick(); rst = 0;
    // R1 reset state
    chk("R1 memReq", memReq, 0);
    chk("R1 busy", busy, 0);
    chk("R1 pulses", {writeDone, readMore, resume}, 0);

    // R5 block selector, drained outbound -> writeDone
    upperBlock = 32'h5; dirOut = 1;
    loadM(100, 32'h1000); setDev(40);
    step("A", 40, 3'b100);

    // R2 zero device length: no request until nonzero arrives
    upperData = 32'h7;
    go = 1; tick(); go = 0;
    for (int i = 0; i < 5; i++) begin
      chk("R2 no request", memReq, 0); tick();
    end
    setDev(200);
    tick();
    chk("R2 request after length", memReq, 1);
    chk("R3 len min", memLen, 60);
    chk("R5 data selector wins", memAddr, {32'h7, 32'h1028});
    // R6 hold while no ack; R9 loads ignored during request
    devLen = 3; devLenValid = 1; loadMove = 1; loadCount = 9;
    tick(); devLenValid = 0; loadMove = 0;
    for (int i = 0; i < 3; i++) begin
      chk("R6 held", memReq, 1);
      chk("R6 addr stable", memAddr, {32'h7, 32'h1028});
      tick();
    end
    memAck = 1; tick(); memAck = 0;
    chk("R8 resume R9", {writeDone, readMore, resume}, 3'b001);
    tick();
    chk("R9 rem after ignored load", remCount, 0);

    // R4 wide modes; single enable bit does not count
    loadM(50, 32'h2000); upperNext = 32'hAB;
    modeCtl = 8'h03; dirOut = 0; setDev(10);
    step("B", 10, 3'b010);                 // 40-bit mode, inbound drain -> readMore
    modeCtl = 8'h04; setDev(20);
    step("C", 20, 3'b010);                 // table-indirect mode
    modeCtl = 8'h01; setDev(30);
    step("D", 20, 3'b001);                 // one bit only -> data selector, rem-limited
    upperData = 0; upperBlock = 0; modeCtl = 0;
    loadM(8, 32'h3000); setDev(8);
    step("E", 8, 3'b010);                  // zero upper half
    chk("R7 cum total", cumCount, 40+60+10+20+20+8);

    // R1 reset again
    rst = 1; tick(); rst = 0;
    chk("R1 cum cleared", cumCount, 0);
    chk("R1 rem cleared", remCount, 0);
    tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule